// File: doc/BRIEF.md
# Device Interrupt Router with Self-Masking Entries

This block sits between a set of device interrupt lines and the processor interrupt fabric. Each device owns one entry that holds a target CPU number, a vector, a mask bit and a pending bit. Software configures the entries through a simple word-addressed register port, with one 64-bit word per register on an 8-byte stride. For each entry, the routing words come first, and a second bank of control words follows them.

A rising edge on a device line is accepted only if its entry is unmasked. When it is accepted, the entry records pending, masks itself, and queues a post of its CPU and vector toward the fabric. Software must clear pending through a dedicated clear bit and must unmask the entry before the same device can interrupt again. Posts leave one at a time through a valid/ready handshake. When several entries are waiting, the lowest index wins.

Top module: `dirq_router`

## Requirements
- R1: After reset every entry reads masked (control word 0x4), not pending, with CPU 0 and vector 0. No post is presented, and reg_err and reg_rvalid are low.
- R2: The routing word of entry i sits at byte offset 8*i. A write loads the CPU from bits 12:8 and the vector from bits 5:0. A read returns those fields in the same positions, with every other bit zero.
- R3: The control word of entry i sits at byte offset 8*(NUM_DEV+i) and reads mask at bit 2, pending at bit 0, and zero elsewhere. A write loads mask from bit 2. A 1 in bit 1 clears pending. A 0 in bit 1 leaves pending unchanged.
- R4: A rising edge on the device line of an unmasked entry sets both pending and mask, and queues a post carrying that entry's CPU and vector.
- R5: A rising edge on a masked entry is dropped. The control word is unchanged and no post is made.
- R6: Device lines are edge sensitive. A line held high causes one capture only, and unmasking while it stays high makes no new post.
- R7: post_valid, once raised, holds with stable post_cpu and post_vec until post_ready is seen high at a clock edge. Exactly one post is transferred per such edge.
- R8: Entries captured in the same cycle post in ascending index order. The waiting entries keep reading pending and masked.
- R9: A read or write at an offset that is not 8-byte aligned, or that lies beyond the last control word, reads as zero and changes no state. Such an access raises reg_err for one cycle, in the cycle after the access. Mapped accesses leave reg_err low.
- R10: Read data and reg_rvalid appear in the cycle after reg_rd is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | NUM_DEV | Device interrupt lines, rising-edge detected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| reg_err | output | 1 | One-cycle flag for an unmapped access |
| post_valid | output | 1 | Post request to the interrupt fabric |
| post_ready | input | 1 | Fabric accepts the post |
| post_cpu | output | CPU_W | Target CPU of the post |
| post_vec | output | VEC_W | Vector of the post |

## Verification
The bench holds a device line high and then unmasks the entry. A design that decoded levels instead of edges would post a second time, and the scoreboard catches this as an unexpected post. Three entries fire in one cycle while the fabric stalls. A wrong priority order would show up as a mismatch against the queued CPU and vector, and a post that drifted during the stall would fail the hold check. The bench also writes zero to the clear bit and checks that pending survives. It targets misaligned and out-of-range offsets and then reads back a neighbouring entry, so a loose address decode that aliased writes onto a real entry would be visible.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int WORD_W        = 64;
  localparam int STRIDE_LG     = 3;
  localparam int ROUTE_CPU_LSB = 8;
  localparam int ROUTE_VEC_LSB = 0;
  localparam int CTRL_MASK_BIT = 2;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_PEND_BIT = 0;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_ROUTE = 2'd1,
    RGN_CTRL  = 2'd2
  } rgn_e;
endpackage

// File: rtl/dirq_decode.sv
module dirq_decode
  import dirq_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              region,
  output logic [IDX_W-1:0]  idx
);
  localparam int WAW = ADDR_W - STRIDE_LG;

  logic [WAW-1:0] word;
  assign word = addr[ADDR_W-1:STRIDE_LG];

  always_comb begin
    region = RGN_NONE;
    idx    = '0;
    if (addr[STRIDE_LG-1:0] == '0) begin
      if (int'(word) < NUM_DEV) begin
        region = RGN_ROUTE;
        idx    = IDX_W'(int'(word));
      end else if (int'(word) < 2 * NUM_DEV) begin
        region = RGN_CTRL;
        idx    = IDX_W'(int'(word) - NUM_DEV);
      end
    end
  end
endmodule

// File: rtl/dirq_edge.sv
module dirq_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line,
  output logic [N-1:0] rise
);
  logic [N-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line;
  end

  assign rise = line & ~line_q;
endmodule

// File: rtl/dirq_bank.sv
module dirq_bank #(
  parameter int NUM_DEV = 8,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_route,
  input  logic             wr_ctrl,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CPU_W-1:0] wr_cpu,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             wr_mask,
  input  logic             wr_clr,
  input  logic [NUM_DEV-1:0] rise,
  input  logic [NUM_DEV-1:0] grant,
  output logic [CPU_W-1:0] ent_cpu [NUM_DEV],
  output logic [VEC_W-1:0] ent_vec [NUM_DEV],
  output logic [NUM_DEV-1:0] ent_mask,
  output logic [NUM_DEV-1:0] ent_pend,
  output logic [NUM_DEV-1:0] ent_req
);
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_ent
    logic hit_route, hit_ctrl, accept;

    assign hit_route = wr_route && (wr_idx == IDX_W'(i));
    assign hit_ctrl  = wr_ctrl  && (wr_idx == IDX_W'(i));
    assign accept    = rise[i] && !ent_mask[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_cpu[i]  <= '0;
        ent_vec[i]  <= '0;
        ent_mask[i] <= 1'b1;
        ent_pend[i] <= 1'b0;
        ent_req[i]  <= 1'b0;
      end else begin
        if (hit_route) begin
          ent_cpu[i] <= wr_cpu;
          ent_vec[i] <= wr_vec;
        end
        if (hit_ctrl) begin
          ent_mask[i] <= wr_mask;
          if (wr_clr) ent_pend[i] <= 1'b0;
        end
        if (grant[i]) ent_req[i] <= 1'b0;
        // a capture overrides a software write landing in the same cycle
        if (accept) begin
          ent_mask[i] <= 1'b1;
          ent_pend[i] <= 1'b1;
          ent_req[i]  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dirq_post.sv
module dirq_post #(
  parameter int NUM_DEV = 8,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] req,
  input  logic [CPU_W-1:0]   ent_cpu [NUM_DEV],
  input  logic [VEC_W-1:0]   ent_vec [NUM_DEV],
  input  logic               post_ready,
  output logic [NUM_DEV-1:0] grant,
  output logic               post_valid,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec
);
  logic             can_load;
  logic             found;
  logic [IDX_W-1:0] sel;

  assign can_load = !post_valid || post_ready;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_DEV; i++)
      grant[i] = can_load && found && (sel == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else if (can_load) begin
      post_valid <= found;
      if (found) begin
        post_cpu <= ent_cpu[sel];
        post_vec <= ent_vec[sel];
      end
    end
  end
endmodule

// File: rtl/dirq_router.sv
module dirq_router
  import dirq_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] dev_irq,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               reg_rvalid,
  output logic               reg_err,
  output logic               post_valid,
  input  logic               post_ready,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec
);
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  rgn_e               region;
  logic [IDX_W-1:0]   idx;
  logic [NUM_DEV-1:0] rise;
  logic [NUM_DEV-1:0] arb_grant;
  logic [CPU_W-1:0]   ent_cpu [NUM_DEV];
  logic [VEC_W-1:0]   ent_vec [NUM_DEV];
  logic [NUM_DEV-1:0] ent_mask, ent_pend, ent_req;
  logic [WORD_W-1:0]  rd_word;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata;

  dirq_decode #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(reg_addr), .region(region), .idx(idx)
  );

  dirq_edge #(.N(NUM_DEV)) u_edge (
    .clk(clk), .rst(rst), .line(dev_irq), .rise(rise)
  );

  dirq_bank #(.NUM_DEV(NUM_DEV), .CPU_W(CPU_W), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_route(reg_wr && region == RGN_ROUTE),
    .wr_ctrl (reg_wr && region == RGN_CTRL),
    .wr_idx  (idx),
    .wr_cpu  (reg_wdata[ROUTE_CPU_LSB +: CPU_W]),
    .wr_vec  (reg_wdata[ROUTE_VEC_LSB +: VEC_W]),
    .wr_mask (reg_wdata[CTRL_MASK_BIT]),
    .wr_clr  (reg_wdata[CTRL_CLR_BIT]),
    .rise(rise), .grant(arb_grant),
    .ent_cpu(ent_cpu), .ent_vec(ent_vec),
    .ent_mask(ent_mask), .ent_pend(ent_pend), .ent_req(ent_req)
  );

  dirq_post #(.NUM_DEV(NUM_DEV), .CPU_W(CPU_W), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_post (
    .clk(clk), .rst(rst), .req(ent_req),
    .ent_cpu(ent_cpu), .ent_vec(ent_vec),
    .post_ready(post_ready), .grant(arb_grant),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
  );

  always_comb begin
    rd_word = '0;
    case (region)
      RGN_ROUTE: begin
        rd_word[ROUTE_CPU_LSB +: CPU_W] = ent_cpu[idx];
        rd_word[ROUTE_VEC_LSB +: VEC_W] = ent_vec[idx];
      end
      RGN_CTRL: begin
        rd_word[CTRL_MASK_BIT] = ent_mask[idx];
        rd_word[CTRL_PEND_BIT] = ent_pend[idx];
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      reg_err    <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      reg_err    <= (reg_rd || reg_wr) && (region == RGN_NONE);
      if (reg_rd) reg_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/dirq_router_chk.sv
module dirq_router_chk #(
  parameter int NUM_DEV = 8,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic               reg_err,
  input logic               reg_rvalid,
  input logic [63:0]        reg_rdata,
  input logic               post_valid,
  input logic               post_ready,
  input logic [CPU_W-1:0]   post_cpu,
  input logic [VEC_W-1:0]   post_vec,
  input logic [NUM_DEV-1:0] grant,
  input logic [NUM_DEV-1:0] mask,
  input logic [NUM_DEV-1:0] pend
);
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !post_valid && !reg_rvalid && !reg_err); // R1

  AST_CAPTURE_MASKS: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) & ~mask) == '0); // R4

  AST_POST_HOLD: assert property (@(posedge clk) disable iff (rst)
    post_valid && !post_ready |=> post_valid && $stable(post_cpu) && $stable(post_vec)); // R7

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R8

  AST_GRANT_PRESENTS: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |=> post_valid); // R8

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !reg_rd && !reg_wr |=> !reg_err); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid && reg_err |-> reg_rdata == '0); // R9

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R10
endmodule

bind dirq_router dirq_router_chk #(.NUM_DEV(NUM_DEV), .CPU_W(CPU_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_err(reg_err),
  .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .post_valid(post_valid),
  .post_ready(post_ready), .post_cpu(post_cpu), .post_vec(post_vec),
  .grant(arb_grant), .mask(ent_mask), .pend(ent_pend)
);

// File: tb/sim_dirq_router.sv
module sim_dirq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEV = 8;
  localparam int CPU_W = 5;
  localparam int VEC_W = 6;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_DEV-1:0] dev_irq = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic reg_rvalid, reg_err, post_valid;
  logic post_ready = 1'b0;
  logic [CPU_W-1:0] post_cpu;
  logic [VEC_W-1:0] post_vec;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;
  logic [CPU_W+VEC_W-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dirq_router #(.NUM_DEV(NUM_DEV), .CPU_W(CPU_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .reg_err(reg_err), .post_valid(post_valid),
    .post_ready(post_ready), .post_cpu(post_cpu), .post_vec(post_vec)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] route_off(input int i);
    return 8'(8 * i);
  endfunction

  function automatic logic [7:0] ctrl_off(input int i);
    return 8'(8 * (NUM_DEV + i));
  endfunction

  task automatic wr(input logic [7:0] a, input logic [63:0] d, output logic e);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    e = reg_err;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d, output logic e);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    e = reg_err;
    chk("R10 rvalid", 64'(reg_rvalid), 64'd1);
  endtask

  task automatic expect_post(input logic [CPU_W-1:0] c, input logic [VEC_W-1:0] v);
    exp_q.push_back({c, v});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  // scoreboard monitor: one post transfers per edge with valid and ready
  always @(negedge clk) begin
    if (!rst && post_valid && post_ready) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R6 unexpected post actual cpu=%0d vec=%0d expected none", post_cpu, post_vec);
      end else begin
        logic [CPU_W+VEC_W-1:0] e;
        e = exp_q.pop_front();
        chk("R4/R7/R8 post", 64'({post_cpu, post_vec}), 64'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post_valid", 64'(post_valid), 64'd0);
    chk("R1 reg_err", 64'(reg_err), 64'd0);
    for (int i = 0; i < NUM_DEV; i++) begin
      rd(ctrl_off(i), d, e);
      chk("R1 ctrl", d, 64'h4);
      rd(route_off(i), d, e);
      chk("R1 route", d, 64'h0);
    end

    // R2: routing fields with junk around them
    wr(route_off(2), 64'h8000_0000_0000_0000 | (64'h13 << 8) | 64'h80 | 64'h2A, e);
    chk("R9 mapped write no err", 64'(e), 64'd0);
    rd(route_off(2), d, e);
    chk("R2 route readback", d, (64'h13 << 8) | 64'h2A);
    chk("R9 mapped read no err", 64'(e), 64'd0);

    // R3: unmask
    wr(ctrl_off(2), 64'h0, e);
    rd(ctrl_off(2), d, e);
    chk("R3 unmasked", d, 64'h0);

    // R4: capture and post
    post_ready = 1'b1;
    expect_post(5'h13, 6'h2A);
    @(negedge clk); dev_irq[2] = 1'b1;
    repeat (4) @(negedge clk);
    rd(ctrl_off(2), d, e);
    chk("R4 pending and masked", d, 64'h5);

    // R3/R6: unmask with line still high, pending kept, no new post
    wr(ctrl_off(2), 64'h0, e);
    rd(ctrl_off(2), d, e);
    chk("R3 clear bit zero keeps pending", d, 64'h1);
    repeat (6) @(negedge clk);
    rd(ctrl_off(2), d, e);
    chk("R6 held line no recapture", d, 64'h1);
    wr(ctrl_off(2), 64'h2, e);
    rd(ctrl_off(2), d, e);
    chk("R3 clear bit clears pending", d, 64'h0);
    expect_post(5'h13, 6'h2A);
    @(negedge clk); dev_irq[2] = 1'b0;
    @(negedge clk); dev_irq[2] = 1'b1;
    repeat (4) @(negedge clk);
    rd(ctrl_off(2), d, e);
    chk("R4 second capture", d, 64'h5);
    chk("R4 posts drained", 64'(exp_q.size()), 64'd0);

    // R5: masked entry drops
    @(negedge clk); dev_irq[5] = 1'b1;
    repeat (6) @(negedge clk);
    rd(ctrl_off(5), d, e);
    chk("R5 masked drop", d, 64'h4);
    chk("R5 no post", 64'(post_valid), 64'd0);

    // R8: three captures in one cycle, fabric stalled
    wr(route_off(1), (64'h01 << 8) | 64'h11, e);
    wr(route_off(3), (64'h03 << 8) | 64'h33, e);
    wr(route_off(6), (64'h1F << 8) | 64'h3F, e);
    wr(ctrl_off(1), 64'h0, e);
    wr(ctrl_off(3), 64'h0, e);
    wr(ctrl_off(6), 64'h0, e);
    post_ready = 1'b0;
    expect_post(5'h01, 6'h11);
    expect_post(5'h03, 6'h33);
    expect_post(5'h1F, 6'h3F);
    @(negedge clk);
    dev_irq[1] = 1'b1; dev_irq[3] = 1'b1; dev_irq[6] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 lowest first valid", 64'(post_valid), 64'd1);
    chk("R8 lowest first", 64'({post_cpu, post_vec}), 64'({5'h01, 6'h11}));
    repeat (4) @(negedge clk);
    chk("R7 hold valid", 64'(post_valid), 64'd1);
    chk("R7 hold payload", 64'({post_cpu, post_vec}), 64'({5'h01, 6'h11}));
    rd(ctrl_off(3), d, e);
    chk("R8 waiter pending", d, 64'h5);
    post_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 all posted in order", 64'(exp_q.size()), 64'd0);
    chk("R7 idle after drain", 64'(post_valid), 64'd0);

    // R9: unmapped and misaligned
    rd(8'h80, d, e);
    chk("R9 out of range reads zero", d, 64'h0);
    chk("R9 out of range err", 64'(e), 64'd1);
    wr(8'h80, 64'hFFFF_FFFF, e);
    chk("R9 write err", 64'(e), 64'd1);
    wr(8'h09, (64'h1E << 8) | 64'h05, e);
    chk("R9 misaligned err", 64'(e), 64'd1);
    @(negedge clk);
    chk("R9 err one cycle", 64'(reg_err), 64'd0);
    rd(route_off(1), d, e);
    chk("R9 neighbour untouched", d, (64'h01 << 8) | 64'h11);
    rd(8'h7C, d, e);
    chk("R9 misaligned ctrl read err", 64'(e), 64'd1);

    repeat (4) @(negedge clk);
    chk("R6 no stray posts", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule